// File: doc/BRIEF.md
# Configurable FEC Symbol Interleaver

This block sits in front of a pair of Reed-Solomon encoders (RS(544,514), 10-bit symbols). It takes a stream of 10-bit symbols, with a flag that marks the first symbol of each codeword. It spreads the symbols over the encoder inputs and produces a merged output stream. In that stream the odd-position symbols can be held back by two codewords. Spreading symbols over two encoders, and delaying the odd ones, scatters an error burst across encoders and across time. The strongest setting lets the code repair a burst of up to 60 symbols, against 15 for a single codeword. It pays for this with two codewords of added latency.

A two-bit mode input picks the interleave depth. The mode is taken only on the first symbol of a codeword.

- **4-way:** the symbols alternate between the two encoders and the odd symbols are delayed.
- **2-way:** the symbols alternate between the two encoders, with no delay.
- **1-way:** every symbol goes to encoder 0, and there is neither alternation nor delay.

The encoders are outside this block. The encoder ports carry the symbols that each encoder would receive. The merged port models the encoders as pass-through.

Top module: `fec_sym_interleaver`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after reset until the first valid input, `enc0_valid`, `enc1_valid` and `out_valid` are low. The block leaves reset in 1-way mode.
- R2: In 2-way and 4-way modes, a valid symbol at an even position goes to the encoder 0 port one cycle later. A valid symbol at an odd position goes to the encoder 1 port one cycle later. Position 0 is the symbol that carries `in_sof`. Exactly one encoder valid is high for each valid input.
- R3: In 1-way mode, every valid symbol appears on the encoder 0 port one cycle later, and `enc1_valid` stays low.
- R4: In 4-way mode, once `out_valid` is high, two things hold one cycle after each input symbol. An even-position symbol appears unchanged on `out_sym`. An odd-position symbol is replaced by the odd-position symbol accepted CW_LEN odd slots earlier, which is exactly two full codewords back.
- R5: In 1-way and 2-way modes, `out_sym`/`out_valid` repeat `in_sym`/`in_valid` one cycle later.
- R6: `mode_sel` is sampled only on a cycle where `in_valid` and `in_sof` are both high, and it is ignored on every other cycle. The codes are 2'b00 = 1-way, 2'b01 = 2-way and 2'b10 = 4-way. The code 2'b11 is treated as 1-way.
- R7: Accepting a mode different from the current one empties the delay history, so no symbol from before the change ever reaches `out_sym`. Accepting the same mode again at a codeword start keeps the history.
- R8: In 4-way mode, `out_valid` stays low until CW_LEN odd-position symbols have been accepted since reset or since the last flush.
- R9: The even/odd position count restarts at every valid `in_sof`, even when the previous codeword was short.
- R10: A cycle with `in_valid` low produces no valid output on any port. It does not advance the position count, and its `in_sof` and `mode_sel` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input symbol valid |
| in_sym | input | SYM_W | Input 10-bit symbol |
| in_sof | input | 1 | First symbol of a codeword |
| mode_sel | input | 2 | Interleave depth request, sampled at codeword start |
| enc0_valid | output | 1 | Symbol valid toward encoder 0 |
| enc0_sym | output | SYM_W | Symbol toward encoder 0 |
| enc1_valid | output | 1 | Symbol valid toward encoder 1 |
| enc1_sym | output | SYM_W | Symbol toward encoder 1 |
| out_valid | output | 1 | Merged stream valid |
| out_sym | output | SYM_W | Merged, optionally delayed, symbol |

## Verification
Full back-to-back codewords in each mode separate the three routings, and they show the exact two-codeword offset of the odd symbols in 4-way. Codewords with idle gaps, in which `in_sof` and `mode_sel` wiggle while `in_valid` is low, show whether idle cycles are truly inert. A truncated codeword followed by a fresh start tells a position count that restarts apart from one that merely alternates. Moving from 4-way to 2-way and back, reapplying 4-way at a boundary, and toggling `mode_sel` mid-codeword or using the reserved code together separate flushing from keeping history, and boundary sampling from free-running sampling.

// File: rtl/fsi_pkg.sv
// Shared types for the FEC symbol interleaver.
// Assumes: the two-bit mode request is decoded only here, so every module
// agrees on the meaning of the reserved code.
package fsi_pkg;

    typedef enum logic [1:0] {
        IL_1WAY = 2'b00,
        IL_2WAY = 2'b01,
        IL_4WAY = 2'b10
    } il_mode_e;

    // Map a raw request code to a mode; the reserved code falls back to 1-way.
    function automatic il_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'b01:   return IL_2WAY;
            2'b10:   return IL_4WAY;
            default: return IL_1WAY;
        endcase
    endfunction

endpackage

// File: rtl/fsi_phase_ctrl.sv
// Mode and symbol-position tracking.
// Keeps the mode in force and whether the next valid symbol sits at an odd
// position. A valid start-of-codeword loads the requested mode and forces
// position 0. A flush pulse is raised when the accepted mode differs from
// the one in force.
// Assumes: idle cycles (in_valid low) carry no meaning at all.
module fsi_phase_ctrl
    import fsi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic [1:0] mode_sel,
    output il_mode_e   cur_mode,
    output logic       cur_odd,
    output logic       flush
);

    il_mode_e mode_q;
    logic     odd_q;
    logic     start;
    il_mode_e req_mode;

    // Decide the mode and position that apply to the symbol on the inputs now.
    always_comb begin
        start    = in_valid && in_sof;
        req_mode = decode_mode(mode_sel);
        cur_mode = start ? req_mode : mode_q;
        cur_odd  = start ? 1'b0 : odd_q;
        flush    = start && (req_mode != mode_q);
    end

    // Advance the mode and position only on accepted symbols.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= IL_1WAY;
            odd_q  <= 1'b0;
        end else if (in_valid) begin
            mode_q <= cur_mode;
            odd_q  <= !cur_odd;
        end
    end

    AST_MODE_ONLY_AT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_sof) |=> $stable(mode_q)); // R6

    AST_IDLE_KEEPS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(odd_q)); // R10

endmodule

// File: rtl/fsi_distrib.sv
// Symbol distribution toward the encoders.
// Registers each valid symbol onto encoder 0 or encoder 1. In 1-way mode
// everything goes to encoder 0; otherwise the position parity picks the
// encoder.
// Assumes: cur_mode/cur_odd already describe the symbol on in_sym.
module fsi_distrib
    import fsi_pkg::*;
#(
    parameter int SYM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SYM_W-1:0] in_sym,
    input  il_mode_e         cur_mode,
    input  logic             cur_odd,
    output logic             enc0_valid,
    output logic [SYM_W-1:0] enc0_sym,
    output logic             enc1_valid,
    output logic [SYM_W-1:0] enc1_sym
);

    logic to_enc1;

    // An odd symbol goes to encoder 1 unless distribution is bypassed.
    always_comb to_enc1 = cur_odd && (cur_mode != IL_1WAY);

    // Present the symbol on the chosen encoder port one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc0_valid <= 1'b0;
            enc1_valid <= 1'b0;
            enc0_sym   <= '0;
            enc1_sym   <= '0;
        end else begin
            enc0_valid <= in_valid && !to_enc1;
            enc1_valid <= in_valid && to_enc1;
            enc0_sym   <= in_sym;
            enc1_sym   <= in_sym;
        end
    end

    AST_ENC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(enc0_valid && enc1_valid)); // R2

    AST_ONE_WAY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cur_mode == IL_1WAY) |=> (enc0_valid && !enc1_valid)); // R3

    AST_EVEN_TO_ENC0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cur_odd) |=> enc0_valid); // R9

endmodule

// File: rtl/fsi_odd_delay.sv
// Odd-symbol delay line.
// A circular buffer of DEPTH symbols, written and read only when an odd
// symbol is accepted in 4-way mode. The read returns the symbol written
// DEPTH writes earlier. A fill counter stands in for clearing the storage:
// until DEPTH writes have happened since reset or flush, the read data is
// zero and `filled` is low.
// Assumes: flush and wr_en never both rise for a useful write, and flush wins.
module fsi_odd_delay #(
    parameter int SYM_W = 10,
    parameter int DEPTH = 544
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             flush,
    input  logic [SYM_W-1:0] wr_sym,
    output logic [SYM_W-1:0] rd_sym,
    output logic             filled
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [SYM_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [CNT_W-1:0] cnt_q;

    // The buffer counts as full once DEPTH writes have landed.
    always_comb begin
        filled = (cnt_q == CNT_W'(DEPTH));
        rd_sym = filled ? mem[ptr_q] : '0;
    end

    // Store the incoming odd symbol over the oldest slot.
    always_ff @(posedge clk) begin
        if (wr_en && !flush) mem[ptr_q] <= wr_sym;
    end

    // Advance the pointer and saturating fill count; flush restarts both.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else if (wr_en) begin
            ptr_q <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
            if (!filled) cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !filled); // R7

    AST_FILL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (filled && !flush) |=> filled); // R8

endmodule

// File: rtl/fec_sym_interleaver.sv
// Configurable FEC symbol interleaver (top).
// Routes 10-bit symbols to two Reed-Solomon encoder ports and builds a merged
// stream with a selectable interleave depth:
//   4-way: alternate encoders, delay odd symbols by DLY_CW codewords;
//   2-way: alternate encoders, no delay;
//   1-way: single encoder, no delay.
// Assumes: CW_LEN is even, so every codeword has CW_LEN/2 odd symbols, and
// the mode request is held valid on the start-of-codeword symbol.
module fec_sym_interleaver
    import fsi_pkg::*;
#(
    parameter int SYM_W  = 10,
    parameter int CW_LEN = 544,
    parameter int DLY_CW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SYM_W-1:0] in_sym,
    input  logic             in_sof,
    input  logic [1:0]       mode_sel,
    output logic             enc0_valid,
    output logic [SYM_W-1:0] enc0_sym,
    output logic             enc1_valid,
    output logic [SYM_W-1:0] enc1_sym,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_sym
);

    localparam int DEPTH = DLY_CW * CW_LEN / 2;

    il_mode_e         cur_mode;
    logic             cur_odd;
    logic             flush;
    logic             dly_wr;
    logic             dly_filled;
    logic [SYM_W-1:0] dly_rd;

    fsi_phase_ctrl u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .mode_sel (mode_sel),
        .cur_mode (cur_mode),
        .cur_odd  (cur_odd),
        .flush    (flush)
    );

    fsi_distrib #(.SYM_W(SYM_W)) u_distrib (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sym     (in_sym),
        .cur_mode   (cur_mode),
        .cur_odd    (cur_odd),
        .enc0_valid (enc0_valid),
        .enc0_sym   (enc0_sym),
        .enc1_valid (enc1_valid),
        .enc1_sym   (enc1_sym)
    );

    // Only odd symbols in 4-way mode pass through the delay line.
    always_comb dly_wr = in_valid && cur_odd && (cur_mode == IL_4WAY);

    fsi_odd_delay #(.SYM_W(SYM_W), .DEPTH(DEPTH)) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (dly_wr),
        .flush  (flush),
        .wr_sym (in_sym),
        .rd_sym (dly_rd),
        .filled (dly_filled)
    );

    // Merge even symbols with (possibly delayed) odd symbols into one stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sym   <= '0;
        end else begin
            out_valid <= in_valid && ((cur_mode != IL_4WAY) || dly_filled);
            out_sym   <= dly_wr ? dly_rd : in_sym;
        end
    end

    AST_FOUR_WAY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cur_mode == IL_4WAY && !dly_filled) |=> !out_valid); // R8

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !enc0_valid && !enc1_valid)); // R10

    AST_BYPASS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cur_mode != IL_4WAY) |=> (out_valid && out_sym == $past(in_sym))); // R5

endmodule

// File: tb/fec_sym_interleaver_tb.sv
// Self-checking bench: a behavioural queue model is stepped alongside the
// design and every output is compared once per clock.
module fec_sym_interleaver_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SYM_W      = 10;
    localparam int CW_LEN     = 544;
    localparam int HIST       = CW_LEN;   // odd slots in two codewords

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [SYM_W-1:0] in_sym = '0;
    logic             in_sof = 1'b0;
    logic [1:0]       mode_sel = 2'b00;
    logic             enc0_valid, enc1_valid, out_valid;
    logic [SYM_W-1:0] enc0_sym, enc1_sym, out_sym;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int               m_ways = 1;
    bit               m_odd_next = 0;
    logic [SYM_W-1:0] m_hist[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fec_sym_interleaver u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sym(in_sym),
        .in_sof(in_sof), .mode_sel(mode_sel),
        .enc0_valid(enc0_valid), .enc0_sym(enc0_sym),
        .enc1_valid(enc1_valid), .enc1_sym(enc1_sym),
        .out_valid(out_valid), .out_sym(out_sym)
    );

    function automatic int ways_of(input logic [1:0] c);
        if (c == 2'b10) return 4;
        if (c == 2'b01) return 2;
        return 1;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            if (errors <= 30)
                $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: drive at a falling edge, update the model, compare at the next falling edge.
    task automatic step(input logic v, input logic [SYM_W-1:0] s, input logic sof,
                        input logic [1:0] m, input string tag);
        bit e0v = 0, e1v = 0, ov = 0, odd = 0;
        logic [SYM_W-1:0] os = '0;
        in_valid = v; in_sym = s; in_sof = sof; mode_sel = m;
        if (!rst_n) begin
            m_ways = 1; m_odd_next = 0; m_hist.delete();
        end else if (v) begin
            if (sof) begin
                if (ways_of(m) != m_ways) m_hist.delete();
                m_ways = ways_of(m);
                odd = 0;
            end else begin
                odd = m_odd_next;
            end
            m_odd_next = !odd;
            if (m_ways == 1 || !odd) e0v = 1; else e1v = 1;
            if (m_ways != 4) begin
                ov = 1; os = s;
            end else begin
                ov = (m_hist.size() == HIST);
                os = s;
                if (odd) begin
                    if (m_hist.size() == HIST) os = m_hist.pop_front();
                    m_hist.push_back(s);
                end
            end
        end
        @(negedge clk);
        check(tag, "enc0_valid", int'(enc0_valid), int'(e0v));
        check(tag, "enc1_valid", int'(enc1_valid), int'(e1v));
        check(tag, "out_valid",  int'(out_valid),  int'(ov));
        if (e0v) check(tag, "enc0_sym", int'(enc0_sym), int'(s));
        if (e1v) check(tag, "enc1_sym", int'(enc1_sym), int'(s));
        if (ov)  check(tag, "out_sym",  int'(out_sym),  int'(os));
    endtask

    // Send one codeword of n symbols; mode m on the start symbol, mid elsewhere.
    task automatic send_cw(input int n, input logic [1:0] m, input logic [1:0] mid,
                           input int seed, input int gap, input string tag);
        for (int i = 0; i < n; i++) begin
            if (gap != 0 && i != 0 && (i % gap) == 0)
                step(1'b0, SYM_W'(i), 1'b1, 2'(i), tag);
            step(1'b1, SYM_W'(seed * 37 + i * 13 + (i >> 4)), (i == 0), (i == 0) ? m : mid, tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        rst_n = 1'b0;
        step(1'b1, 10'h155, 1'b1, 2'b10, "R1");
        step(1'b1, 10'h2AA, 1'b0, 2'b10, "R1");
        rst_n = 1'b1;
        step(1'b0, '0, 1'b0, 2'b00, "R1");

        // R3: 1-way, mid-codeword mode wiggle ignored (R6)
        send_cw(CW_LEN, 2'b00, 2'b10, 1, 0, "R3");
        // R2: 2-way, gaps with idle sof/mode noise (R10)
        send_cw(CW_LEN, 2'b01, 2'b10, 2, 7, "R2");
        send_cw(CW_LEN, 2'b01, 2'b00, 3, 5, "R10");
        // R9: short codeword then restart
        send_cw(5, 2'b01, 2'b11, 4, 0, "R9");
        send_cw(CW_LEN, 2'b01, 2'b01, 5, 0, "R9");
        // R8 then R4: 4-way fill and steady state, same mode reapplied keeps history (R7)
        send_cw(CW_LEN, 2'b10, 2'b01, 6, 0, "R8");
        send_cw(CW_LEN, 2'b10, 2'b00, 7, 0, "R8");
        send_cw(CW_LEN, 2'b10, 2'b11, 8, 0, "R4");
        send_cw(CW_LEN, 2'b10, 2'b01, 9, 3, "R4");
        // R5: 2-way after 4-way, then back to 4-way must start empty (R7)
        send_cw(CW_LEN, 2'b01, 2'b10, 10, 0, "R5");
        send_cw(CW_LEN, 2'b10, 2'b00, 11, 0, "R7");
        send_cw(CW_LEN, 2'b10, 2'b00, 12, 0, "R7");
        send_cw(CW_LEN, 2'b10, 2'b00, 13, 0, "R7");
        // R6: reserved code behaves as 1-way
        send_cw(CW_LEN, 2'b11, 2'b10, 14, 0, "R6");
        step(1'b0, '0, 1'b0, 2'b00, "R10");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule